// File: doc/BRIEF.md
# Transparent Transmit Character Unpacker

This block turns one transmit buffer held in byte-addressed memory into a stream of serial characters. A descriptor gives the buffer's start pointer, its length in octets and a flag marking it as the final buffer of a frame. The character width can be set from 5 to 16 bits. The descriptor is taken with a one-cycle `start` pulse while the block is idle.

The memory is read one byte at a time over a request/acknowledge port. A character of 8 bits or fewer takes one byte. A wider character takes a half word of two bytes. The byte at the lower address holds the upper eight bits of that half word. Characters leave on a valid/ready stream, and the final character of the buffer carries a last flag.

The block checks the descriptor before it reads any memory. A wide character needs an even length and an even pointer. A width outside 5..16 is also refused. A refused descriptor raises a one-cycle error pulse. When the buffer has been fully handed over, the block raises a one-cycle done pulse, together with a pulse that repeats the final-buffer flag. The block never changes the descriptor: the length is copied into a private counter.

Top module: `tx_char_unpacker`

## Requirements
- R1: After reset `busy`, `mem_req`, `ch_valid`, `buf_done`, `buf_last` and `desc_err` are all low.
- R2: For widths 5..8, each character is one byte. The bytes are read at addresses `desc_ptr`, `desc_ptr+1`, and so on. `desc_len` characters are sent, and the pointer and the length may each be odd.
- R3: For widths 9..16, each character is formed from two consecutive bytes. The first byte read fills `ch_data[15:8]` and the second fills `ch_data[7:0]`. `desc_len/2` characters are sent.
- R4: `ch_data` bits at and above the programmed width are always zero. Source bits beyond the width are dropped.
- R5: With a width above 8, an odd `desc_len` or an odd `desc_ptr` makes `desc_err` pulse one cycle after `start`. No memory read, no character and no done pulse follow.
- R6: A width below 5 or above 16 makes `desc_err` pulse one cycle after `start`. Nothing is sent.
- R7: A length of zero makes `buf_done` pulse one cycle after `start`, with no memory read and no character.
- R8: `ch_last` is high on the final character of the buffer and low on every other character.
- R9: `buf_done` pulses one cycle after the final character's handshake. `buf_last` pulses with it exactly when the descriptor's last flag was set.
- R10: While `ch_valid` is high and `ch_ready` is low, `ch_valid`, `ch_data` and `ch_last` hold their values.
- R11: A `start` pulse while `busy` is high is ignored. The running buffer completes unchanged.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Descriptor valid pulse, taken only when idle |
| desc_ptr | input | AW | Buffer start byte address |
| desc_len | input | LW | Buffer length in octets |
| desc_last | input | 1 | Buffer is the final one of the frame |
| char_width | input | 5 | Character width in bits, 5..16 legal |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | AW | Byte read address |
| mem_ack | input | 1 | Read complete, `mem_rdata` valid |
| mem_rdata | input | 8 | Read data byte |
| ch_valid | output | 1 | Character available |
| ch_ready | input | 1 | Consumer accepts character |
| ch_data | output | 16 | Character, right aligned |
| ch_last | output | 1 | Final character of the buffer |
| busy | output | 1 | A buffer is in progress |
| buf_done | output | 1 | One-cycle pulse: buffer handed over |
| buf_last | output | 1 | One-cycle pulse with `buf_done` when the last flag was set |
| desc_err | output | 1 | One-cycle pulse: descriptor refused |

## Verification
The hardest case to reach is the interaction of backpressure with memory latency in wide mode. The second byte of a half word must not be lost while a stalled character waits, and the pointer must still advance correctly. The bench gets there with a memory model that acknowledges after a delay and a consumer that accepts only one cycle in three. It also sends a second `start` into a running buffer to show that the descriptor latch is protected.

// File: rtl/tx_char_unpacker.sv
module tx_char_unpacker #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] desc_ptr,
  input  logic [LW-1:0] desc_len,
  input  logic          desc_last,
  input  logic [4:0]    char_width,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          ch_valid,
  input  logic          ch_ready,
  output logic [15:0]   ch_data,
  output logic          ch_last,
  output logic          busy,
  output logic          buf_done,
  output logic          buf_last,
  output logic          desc_err
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} state_t;
  state_t state;

  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic          wide_q, lastf_q, hi_q, clast_q;
  logic [4:0]    cw_q;
  logic [7:0]    hi_byte_q;
  logic [15:0]   data_q;
  logic          done_q, blast_q, err_q;

  wire        take     = start && state == S_IDLE;
  wire        bad_w    = char_width < 5'd5 || char_width > 5'd16;
  wire        wide_in  = char_width > 5'd8;
  wire        bad_al   = wide_in && (desc_len[0] || desc_ptr[0]);
  wire        got      = state == S_FETCH && mem_ack;
  wire [15:0] mask     = 16'((17'd1 << cw_q) - 17'd1);
  wire [15:0] raw      = wide_q ? {hi_byte_q, mem_rdata} : {8'h00, mem_rdata};

  assign mem_req  = state == S_FETCH;
  assign mem_addr = addr_q;
  assign ch_valid = state == S_SEND;
  assign ch_data  = data_q;
  assign ch_last  = clast_q;
  assign busy     = state != S_IDLE;
  assign buf_done = done_q;
  assign buf_last = blast_q;
  assign desc_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      wide_q    <= 1'b0;
      lastf_q   <= 1'b0;
      hi_q      <= 1'b0;
      clast_q   <= 1'b0;
      cw_q      <= 5'd8;
      hi_byte_q <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      blast_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      blast_q <= 1'b0;
      err_q   <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (bad_w || bad_al) begin
            err_q <= 1'b1;
          end else if (desc_len == '0) begin
            done_q  <= 1'b1;
            blast_q <= desc_last;
          end else begin
            state   <= S_FETCH;
            addr_q  <= desc_ptr;
            rem_q   <= desc_len;
            wide_q  <= wide_in;
            lastf_q <= desc_last;
            cw_q    <= char_width;
            hi_q    <= 1'b0;
          end
        end
        S_FETCH: if (got) begin
          addr_q <= addr_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
          if (wide_q && !hi_q) begin
            hi_byte_q <= mem_rdata;
            hi_q      <= 1'b1;
          end else begin
            data_q  <= raw & mask;
            hi_q    <= 1'b0;
            clast_q <= rem_q == LW'(1);
            state   <= S_SEND;
          end
        end
        S_SEND: if (ch_ready) begin
          if (clast_q) begin
            state   <= S_IDLE;
            done_q  <= 1'b1;
            blast_q <= lastf_q;
          end else begin
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !ch_valid);

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> (ch_data & ~mask) == 16'h0);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> !busy && !buf_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> !ch_valid && !mem_req);

  p_last_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_last |-> buf_done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid && !ch_ready |=> ch_valid && $stable(ch_data) && $stable(ch_last));

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

// File: tb/tx_char_unpacker_bench.sv
module tx_char_unpacker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] desc_ptr = '0, desc_len = '0;
  logic        desc_last = 1'b0;
  logic [4:0]  char_width = 5'd8;
  logic        mem_req, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        ch_valid, ch_ready = 1'b1, ch_last;
  logic [15:0] ch_data;
  logic        busy, buf_done, buf_last, desc_err;

  tx_char_unpacker u_tx_char_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_ptr(desc_ptr),
    .desc_len(desc_len), .desc_last(desc_last), .char_width(char_width),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_data(ch_data), .ch_last(ch_last), .busy(busy), .buf_done(buf_done),
    .buf_last(buf_last), .desc_err(desc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int mem_delay = 0, stall = 0;
  int n_got, n_ack, n_done, n_blast, n_err, hs_cyc, done_cyc, err_cyc;
  logic [15:0] got_d [0:63];
  logic        got_l [0:63];

  function automatic logic [7:0] mbyte(input int a);
    return 8'((a % 64) * 29 + 91);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model with programmable latency; also watches R12
  int wcnt = 0;
  bit pw = 0;
  logic [15:0] paddr;
  always @(negedge clk) begin
    if (rst_n && pw) check(mem_req && mem_addr == paddr, "R12", int'(mem_addr), int'(paddr));
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && wcnt >= mem_delay) begin
      mem_ack = 1'b1;
      mem_rdata = mbyte(int'(mem_addr));
      wcnt = 0;
      n_ack++;
    end else if (mem_req) begin
      wcnt++;
    end
    pw = mem_req && !mem_ack;
    paddr = mem_addr;
  end

  // consumer and event monitor; also watches R10
  bit pend = 0;
  logic [15:0] pd;
  logic pl;
  always @(negedge clk) begin
    if (rst_n && pend)
      check(ch_valid && ch_data == pd && ch_last == pl, "R10", int'(ch_data), int'(pd));
    ch_ready = (stall == 0) || (cyc % 3 == 0);
    if (ch_valid && ch_ready) begin
      if (n_got < 64) begin
        got_d[n_got] = ch_data;
        got_l[n_got] = ch_last;
      end
      n_got++;
      hs_cyc = cyc;
    end
    pend = ch_valid && !ch_ready;
    pd = ch_data;
    pl = ch_last;
    if (buf_done) begin n_done++; done_cyc = cyc; end
    if (buf_last) n_blast++;
    if (desc_err) begin n_err++; err_cyc = cyc; end
  end

  task automatic run(input int ptr, input int len, input bit lst, input int cw,
                     input int stl, input int dly, input bit intrude, input string req);
    int s_cyc, n_exp, waited;
    bit wide, exp_err;
    logic [15:0] msk, e;
    n_got = 0; n_ack = 0; n_done = 0; n_blast = 0; n_err = 0;
    hs_cyc = -1; done_cyc = -1; err_cyc = -1;
    stall = stl; mem_delay = dly;
    wide = cw > 8;
    exp_err = cw < 5 || cw > 16 || (wide && (len % 2 != 0 || ptr % 2 != 0));
    n_exp = exp_err ? 0 : (wide ? len / 2 : len);
    msk = 16'((17'd1 << cw) - 17'd1);
    @(negedge clk);
    desc_ptr = 16'(ptr); desc_len = 16'(len); desc_last = lst; char_width = 5'(cw);
    start = 1'b1; s_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      desc_ptr = 16'd40; desc_len = 16'd2; desc_last = ~lst; char_width = 5'd16;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (n_done == 0 && n_err == 0 && waited < 600) begin
      @(negedge clk); waited++;
    end
    repeat (4) @(negedge clk);
    if (exp_err) begin
      check(n_err == 1 && err_cyc == s_cyc + 1, req, err_cyc, s_cyc + 1);
      check(n_ack == 0 && n_got == 0 && n_done == 0, req, n_ack + n_got + n_done, 0);
    end else begin
      check(n_err == 0, req, n_err, 0);
      check(n_got == n_exp, {req, " count"}, n_got, n_exp);
      check(n_ack == (wide ? 2 * n_exp : n_exp), {req, " reads"}, n_ack, wide ? 2 * n_exp : n_exp);
      for (int k = 0; k < n_exp && k < n_got; k++) begin
        e = wide ? {mbyte(ptr + 2*k), mbyte(ptr + 2*k + 1)} : {8'h00, mbyte(ptr + k)};
        e = e & msk;
        check(got_d[k] == e, {req, " data R4"}, int'(got_d[k]), int'(e));
        check(got_l[k] == (k == n_exp - 1), "R8 last flag", int'(got_l[k]), int'(k == n_exp - 1));
      end
      check(n_done == 1, "R9 done count", n_done, 1);
      check(n_blast == (lst ? 1 : 0), "R9 last pulse", n_blast, lst ? 1 : 0);
      if (n_exp == 0)
        check(done_cyc == s_cyc + 1, "R7 done timing", done_cyc, s_cyc + 1);
      else
        check(done_cyc == hs_cyc + 1, "R9 done timing", done_cyc, hs_cyc + 1);
    end
    check(!busy && !ch_valid && !mem_req, {req, " idle after"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !ch_valid && !buf_done && !buf_last && !desc_err,
          "R1 reset", int'({busy, mem_req, ch_valid, buf_done, buf_last, desc_err}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_narrow();
    run(3, 3, 1, 8, 0, 0, 0, "R2 narrow odd ptr");
    run(10, 5, 0, 5, 1, 2, 0, "R2 narrow width5 stalled");
  endtask

  task automatic t_wide();
    run(6, 6, 1, 9, 0, 0, 0, "R3 wide 9");
    run(20, 8, 0, 16, 1, 1, 0, "R3 wide 16 stalled");
    run(62, 4, 1, 12, 1, 3, 0, "R3 wide 12 wrap");
  endtask

  task automatic t_align();
    run(8, 5, 0, 12, 0, 0, 0, "R5 odd length");
    run(7, 4, 1, 10, 0, 0, 0, "R5 odd pointer");
  endtask

  task automatic t_badwidth();
    run(0, 4, 0, 4, 0, 0, 0, "R6 width 4");
    run(0, 4, 0, 17, 0, 0, 0, "R6 width 17");
  endtask

  task automatic t_zero();
    run(5, 0, 1, 8, 0, 0, 0, "R7 zero length");
    run(5, 0, 0, 16, 0, 0, 0, "R7 zero length wide");
  endtask

  task automatic t_busy();
    run(0, 4, 1, 7, 1, 1, 1, "R11 start while busy");
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_align();
    t_badwidth();
    t_zero();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule